// File: doc/BRIEF.md
# Clock-Change Settling Watchdog

This block holds the processor still while a freshly reprogrammed clock settles. A strobe from the frequency control register raises a hold output. The hold stays up until an 8-bit up-counter wraps from its top value back to zero. The counter advances once per programmable number of peripheral-clock enable pulses, so software picks the settling time by choosing the prescale and the counter's starting value before it touches the frequency register.

Software reaches the counter and a small control/status byte through a 16-bit write port. A write lands only when its upper byte carries the key that belongs to the target register. The counter and its prescaler run while hold is active or while the control byte's enable bit is set. Otherwise they sit idle, and the prescaler drops back to zero. Each wrap of the counter also leaves a sticky flag in the control byte.

Top module: `clk_settle_wdt`

## Requirements
- R1: After reset the counter reads 0x00, the control byte reads 0x00 and hold_o is low.
- R2: A write with wr_sel_i=0 and upper byte 0x5A loads the low byte into the counter on the next edge, so 0x5A00 clears it.
- R3: A write with wr_sel_i=1 and upper byte 0xA5 loads prescale select bits [2:0] and enable bit 5 from the low byte and clears flag bit 7. All other control bits read 0.
- R4: A write whose upper byte does not match the key of the selected register leaves that register unchanged.
- R5: Select values 0 to 7 divide the enable pulses by 1, 4, 16, 32, 64, 256, 1024 and 4096. While running, the counter advances once per that many pulses of pclk_en_i, counted from a prescaler at zero.
- R6: With hold low and enable clear, the counter does not move and the prescaler returns to zero, so a later run starts a fresh prescale period.
- R7: A pulse on freq_wr_i raises hold_o on the next edge. hold_o falls on the edge where the counter wraps from 0xFF to 0x00.
- R8: A wrap sets flag bit 7, which stays set until a keyed control write. A wrap in the same cycle as a keyed control write leaves the flag set.
- R9: A freq_wr_i pulse while hold is already high neither restarts the counter nor the prescaler. Hold ends at the next wrap.
- R10: A freq_wr_i pulse in the cycle of a wrap keeps hold_o high until the following wrap.
- R11: A keyed counter write in the same cycle as a prescaler tick takes priority: the written value lands and no wrap occurs.
- R12: With a prescale of 16, the counter at zero and pclk_en_i high on every cycle, hold_o stays high for exactly 4096 cycles after a frequency write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pclk_en_i | input | 1 | Peripheral-clock enable pulse, the count source |
| freq_wr_i | input | 1 | Strobe: the frequency control register was written |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 1 | Write target: 0 counter, 1 control byte |
| wr_data_i | input | 16 | Write data, key in bits [15:8] |
| cnt_o | output | 8 | Current counter value |
| ctrl_o | output | 8 | Control byte: [7] flag, [5] enable, [2:0] prescale select |
| hold_o | output | 1 | CPU hold during clock settling |

## Verification
Because the prescaler cannot be seen at the ports, a wrong prescaler phase or a missing restart shows up only as a counter step that comes one or more enable pulses early or late. A run at a known division brings this to the count value. A wrong hold state lengthens or shortens the stall by a whole counter period, or leaves it hung. This is visible on hold_o within one wrap. Key mistakes and priority mistakes at coinciding events change cnt_o or ctrl_o on the very next edge. That is why the bench drives such collisions on purpose and compares every cycle against a behavioural model.

// File: rtl/clk_settle_pkg.sv
package clk_settle_pkg;
  localparam logic [7:0] CNT_KEY  = 8'h5A;
  localparam logic [7:0] CTRL_KEY = 8'hA5;
  localparam int FLAG_BIT = 7;
  localparam int TME_BIT  = 5;
  localparam int SEL_W    = 3;

  typedef enum logic [SEL_W-1:0] {
    DIV_1, DIV_4, DIV_16, DIV_32, DIV_64, DIV_256, DIV_1024, DIV_4096
  } psc_sel_e;

  function automatic int unsigned psc_shift(input psc_sel_e sel);
    case (sel)
      DIV_1:    return 0;
      DIV_4:    return 2;
      DIV_16:   return 4;
      DIV_32:   return 5;
      DIV_64:   return 6;
      DIV_256:  return 8;
      DIV_1024: return 10;
      default:  return 12;
    endcase
  endfunction
endpackage

// File: rtl/cs_prescaler.sv
module cs_prescaler
  import clk_settle_pkg::*;
#(
  parameter int PSC_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             pclk_en_i,
  input  psc_sel_e         sel_i,
  output logic             tick_o
);
  localparam logic [PSC_W-1:0] ONE = {{(PSC_W-1){1'b0}}, 1'b1};

  logic [PSC_W-1:0] psc_q;
  logic [PSC_W-1:0] mask;

  // mask wraps to all ones for the widest division
  assign mask   = (ONE << psc_shift(sel_i)) - ONE;
  assign tick_o = run_i & pclk_en_i & ((psc_q & mask) == mask);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        psc_q <= '0;
    else if (!run_i)    psc_q <= '0;
    else if (pclk_en_i) psc_q <= psc_q + ONE;
  end
endmodule

// File: rtl/cs_counter.sv
module cs_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             ld_i,
  input  logic [CNT_W-1:0] ld_val_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o
);
  logic [CNT_W-1:0] cnt_q;

  // a load beats a tick in the same cycle
  assign wrap_o = tick_i & ~ld_i & (&cnt_q);
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (ld_i)   cnt_q <= ld_val_i;
    else if (tick_i) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/cs_ctrl_reg.sv
module cs_ctrl_reg
  import clk_settle_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_i,
  input  logic [7:0] din_i,
  input  logic       wrap_i,
  output psc_sel_e   sel_o,
  output logic       tme_o,
  output logic [7:0] ctrl_o
);
  logic flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_o  <= DIV_1;
      tme_o  <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      if (wr_i) begin
        sel_o  <= psc_sel_e'(din_i[SEL_W-1:0]);
        tme_o  <= din_i[TME_BIT];
        flag_q <= 1'b0;
      end
      if (wrap_i) flag_q <= 1'b1;  // set wins over clear
    end
  end

  always_comb begin
    ctrl_o                = '0;
    ctrl_o[SEL_W-1:0]     = sel_o;
    ctrl_o[TME_BIT]       = tme_o;
    ctrl_o[FLAG_BIT]      = flag_q;
  end
endmodule

// File: rtl/clk_settle_wdt.sv
module clk_settle_wdt
  import clk_settle_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int PSC_W  = 12,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pclk_en_i,
  input  logic              freq_wr_i,
  input  logic              wr_en_i,
  input  logic              wr_sel_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [CNT_W-1:0]  cnt_o,
  output logic [7:0]        ctrl_o,
  output logic              hold_o
);
  localparam int KEY_W = 8;

  logic [KEY_W-1:0] key;
  logic             cnt_wr, ctrl_wr;
  logic             run, tick, wrap, tme, hold_q;
  psc_sel_e         sel;

  assign key     = wr_data_i[DATA_W-1 -: KEY_W];
  assign cnt_wr  = wr_en_i & ~wr_sel_i & (key == CNT_KEY);
  assign ctrl_wr = wr_en_i &  wr_sel_i & (key == CTRL_KEY);
  assign run     = hold_q | tme;

  cs_prescaler #(.PSC_W(PSC_W)) u_psc (
    .clk_i, .rst_ni, .run_i(run), .pclk_en_i, .sel_i(sel), .tick_o(tick)
  );

  cs_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i, .rst_ni, .tick_i(tick), .ld_i(cnt_wr),
    .ld_val_i(wr_data_i[CNT_W-1:0]), .cnt_o, .wrap_o(wrap)
  );

  cs_ctrl_reg u_ctrl (
    .clk_i, .rst_ni, .wr_i(ctrl_wr), .din_i(wr_data_i[7:0]),
    .wrap_i(wrap), .sel_o(sel), .tme_o(tme), .ctrl_o
  );

  // a new frequency write outranks a coinciding wrap
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        hold_q <= 1'b0;
    else if (freq_wr_i) hold_q <= 1'b1;
    else if (wrap)      hold_q <= 1'b0;
  end

  assign hold_o = hold_q;
endmodule

// File: rtl/cs_settle_chk.sv
module cs_settle_chk #(
  parameter int CNT_W  = 8,
  parameter int DATA_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              freq_wr_i,
  input logic              wr_en_i,
  input logic              wr_sel_i,
  input logic [DATA_W-1:0] wr_data_i,
  input logic [CNT_W-1:0]  cnt_o,
  input logic [7:0]        ctrl_o,
  input logic              hold_o
);
  // R7
  hold_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hold_o) |-> $past(freq_wr_i));

  // R7
  hold_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(hold_o) |-> (cnt_o == '0) && ctrl_o[7]);

  // R8
  flag_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ctrl_o[7]) |-> (cnt_o == '0));

  // R6
  idle_cnt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hold_o && !ctrl_o[5] && !wr_en_i) |=> $stable(cnt_o));

  // R4
  bad_key_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_sel_i && wr_data_i[DATA_W-1 -: 8] != 8'hA5) |=> $stable(ctrl_o[5:0]));

  // R9
  hold_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_o && cnt_o != '1) |=> hold_o);
endmodule

bind clk_settle_wdt cs_settle_chk #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_settle_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .freq_wr_i(freq_wr_i), .wr_en_i(wr_en_i),
  .wr_sel_i(wr_sel_i), .wr_data_i(wr_data_i), .cnt_o(cnt_o), .ctrl_o(ctrl_o),
  .hold_o(hold_o)
);

// File: tb/clk_settle_wdt_tb_top.sv
`timescale 1ns/1ps
module clk_settle_wdt_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pclk_en = 1'b0, freq_wr = 1'b0, wr_en = 1'b0, wr_sel = 1'b0;
  logic [15:0] wr_data = '0;
  logic [7:0]  cnt, ctrl;
  logic        hold;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  clk_settle_wdt dut_i (
    .clk_i(clk), .rst_ni(rst_n), .pclk_en_i(pclk_en), .freq_wr_i(freq_wr),
    .wr_en_i(wr_en), .wr_sel_i(wr_sel), .wr_data_i(wr_data),
    .cnt_o(cnt), .ctrl_o(ctrl), .hold_o(hold)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // behavioural reference model
  int divs[8] = '{1, 4, 16, 32, 64, 256, 1024, 4096};
  int m_cnt, m_psc, m_sel, m_tme, m_flag, m_hold;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_psc = 0; m_sel = 0; m_tme = 0; m_flag = 0; m_hold = 0;
    end else begin
      bit run, tick, cw, kw, wrapped;
      run  = (m_hold != 0) || (m_tme != 0);
      tick = run && pclk_en && ((m_psc + 1) % divs[m_sel] == 0);
      cw   = wr_en && !wr_sel && wr_data[15:8] == 8'h5A;
      kw   = wr_en &&  wr_sel && wr_data[15:8] == 8'hA5;
      wrapped = tick && !cw && m_cnt == 255;
      if (!run) m_psc = 0;
      else if (pclk_en) m_psc = (m_psc + 1) % 4096;
      if (cw) m_cnt = wr_data[7:0];
      else if (tick) m_cnt = (m_cnt + 1) % 256;
      if (kw) begin m_sel = wr_data[2:0]; m_tme = wr_data[5]; m_flag = 0; end
      if (wrapped) m_flag = 1;
      if (freq_wr) m_hold = 1;
      else if (wrapped) m_hold = 0;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R2 model cnt", cnt, m_cnt);
      chk("R3 model ctrl", ctrl, (m_flag << 7) | (m_tme << 5) | m_sel);
      chk("R7 model hold", hold, m_hold);
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input bit sel, input logic [15:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    step(1);
    wr_en = 1'b0;
  endtask

  task automatic fw();
    freq_wr = 1'b1;
    step(1);
    freq_wr = 1'b0;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    done = 1'b1;
    summary();
  end

  initial begin
    int hc;
    step(3);
    rst_n = 1'b1;
    step(1);
    chk("R1 cnt", cnt, 0); chk("R1 ctrl", ctrl, 0); chk("R1 hold", hold, 0);

    wr(0, 16'h1234);  chk("R4 cnt bad key", cnt, 0);
    wr(0, 16'hA537);  chk("R4 cnt ctrl key", cnt, 0);
    wr(1, 16'h5A25);  chk("R4 ctrl bad key", ctrl, 0);
    wr(0, 16'h5A37);  chk("R2 load", cnt, 8'h37);
    wr(0, 16'h5A00);  chk("R2 clear", cnt, 0);

    pclk_en = 1'b1; step(20); pclk_en = 1'b0;
    chk("R6 idle", cnt, 0);

    for (int s = 0; s < 8; s++) begin
      int n;
      wr(1, 16'hA500); wr(0, 16'h5A00);
      wr(1, 16'hA520 | 16'(s));
      chk("R3 ctrl load", ctrl, 8'h20 | s);
      n = (s == 7) ? divs[s] + 3 : divs[s] * 3 + divs[s] / 2;
      pclk_en = 1'b1; step(n); pclk_en = 1'b0;
      step(1);
      chk("R5 prescale", cnt, n / divs[s]);
    end

    wr(1, 16'hA500); wr(0, 16'h5A00);
    wr(1, 16'hA522);
    pclk_en = 1'b1; step(10); pclk_en = 1'b0;
    wr(1, 16'hA502); step(1);
    wr(1, 16'hA522);
    pclk_en = 1'b1; step(10); pclk_en = 1'b0;
    chk("R6 prescaler restart", cnt, 0);

    wr(1, 16'hA502); wr(0, 16'h5A00);
    pclk_en = 1'b1;
    fw();
    chk("R7 hold rise", hold, 1);
    hc = 0;
    while (hold && hc < 10000) begin hc++; step(1); end
    chk("R12 stall length", hc, 4096);
    chk("R7 hold fall", hold, 0);
    chk("R7 cnt at release", cnt, 0);
    chk("R8 flag set", ctrl, 8'h82);
    step(50);
    chk("R8 flag sticky", ctrl, 8'h82);
    wr(1, 16'hA502);
    chk("R3 flag clear", ctrl, 8'h02);

    fw();
    hc = 0;
    while (hold && hc < 10000) begin
      if (hc == 100) freq_wr = 1'b1;
      hc++; step(1);
      freq_wr = 1'b0;
    end
    chk("R9 no restart", hc, 4096);
    pclk_en = 1'b0;

    wr(1, 16'hA500); wr(0, 16'h5AFE);
    fw();
    pclk_en = 1'b1; step(1);
    chk("R10 cnt at top", cnt, 8'hFF);
    freq_wr = 1'b1; step(1); freq_wr = 1'b0;
    chk("R10 hold kept", hold, 1);
    chk("R10 cnt wrapped", cnt, 0);
    chk("R10 flag", ctrl, 8'h80);
    step(255);
    chk("R10 hold before wrap", hold, 1);
    step(1);
    chk("R10 hold after wrap", hold, 0);
    pclk_en = 1'b0;

    wr(1, 16'hA520); wr(0, 16'h5AFF);
    pclk_en = 1'b1; wr(1, 16'hA520); pclk_en = 1'b0;
    chk("R8 set beats clear", ctrl, 8'hA0);
    chk("R8 cnt wrapped", cnt, 0);

    wr(1, 16'hA520); wr(0, 16'h5AFF);
    pclk_en = 1'b1; wr(0, 16'h5A10); pclk_en = 1'b0;
    chk("R11 load wins", cnt, 8'h10);
    chk("R11 no wrap", ctrl, 8'h20);

    step(2);
    done = 1'b1;
    summary();
  end
endmodule